// File: doc/BRIEF.md
# Compare-Match Periodic Timer Group

A small group of 16-bit counting channels that share one byte-addressed register bus. Each channel has a programmable prescaler, an up-counter, a compare register, and a status flag that is raised when the counter reaches the compare value. The compare match can also send the counter back to zero. That gives a fixed-period tick, which software sees on a level interrupt line of its own for each channel.

All run/halt control bits sit together in one register that every channel shares. Software typically sets up a periodic tick in a fixed order. It first halts the channel. It then programs the control, pin-control, compare, counter (to zero), mode and interrupt-enable registers. Last, it sets the channel's run bit.

Clearing the flag takes two steps. Software must first read the status register while the flag is set. It must then write a zero to bit 0. A zero written without that earlier read changes nothing.

Top module: `cmt_group`

## Requirements
- R1: After reset the following reads hold for every channel: control, mode, pin-control, interrupt enable, status and counter read 0; compare reads 0xFFFF; the shared run register reads 0; every interrupt output is low.
- R2: Channel i is decoded at byte base 16*i, at these offsets: control 0x0, mode 0x1, pin-control 0x2, interrupt enable 0x4, status 0x5, counter 0x6, compare 0x8. The shared run register sits at byte 16*NUM_CH (0x30 by default). The 8-bit registers take data bits 7:0 and read back with the upper bits at zero. The counter and compare registers are 16 bits wide. Any address not in this map reads 0.
- R3: Bit i of the shared run register lets channel i count when it is 1. When it is 0, channel i halts and keeps its counter value. A single write can start or halt several channels at once.
- R4: Control bits 2:0 choose the tick rate: 0 gives one tick per clock, 1 one per 4 clocks, 2 one per 16, 3 one per 64, and 4 to 7 one per clock. The prescaler restarts from zero whenever the channel's run bit is 0. So after a run bit is set in edge E, ticks update the counter at edges E+k*N, for k >= 1.
- R5: When control bits 7:5 equal 1, a tick while the counter equals the compare value loads 0, so the counter steps 0..compare and then returns to 0. Any other value of bits 7:5 lets the counter run freely and wrap from 0xFFFF to 0.
- R6: Status bit 0 (the flag) is set on the tick edge at which the counter equals the compare value, whatever the clear setting.
- R7: Status bit 0 clears only when a status read has returned it as 1 and a later status write has data bit 0 equal to 0. A write with bit 0 equal to 1, or a zero written without that earlier read, leaves the flag set. Every status write uses up the earlier read.
- R8: A compare match on the same edge as a clearing status write leaves the flag set.
- R9: A bus write to the counter on the same edge as a tick loads the written value, and the tick is lost.
- R10: Interrupt output i is high exactly while channel i's flag and interrupt-enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe; only a status read uses it, to allow a later flag clear |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, combinational from bus_addr |
| irq | output | NUM_CH (3) | Level interrupt, one per channel |

## Verification
The assertions watch several rules on every cycle:
- a halted counter keeps its value;
- the counter goes to zero after a clearing match;
- the flag rises only on a match tick;
- the flag stays set unless an armed clear arrives;
- a counter write beats a tick;
- the prescaler leaves a gap of at least one clock between ticks at a divided rate.

Some behaviours need the bench's scenarios to show them:
- exact tick counts after a run window for each divider;
- the prescaler restarting after a halt;
- a match landing on the same edge as a clearing write;
- shared run bits that start and halt channels independently;
- the full read-then-write-zero handshake seen through the interrupt pins.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   // byte offsets inside a channel block
   localparam logic [3:0] OFF_CTRL = 4'h0;
   localparam logic [3:0] OFF_MODE = 4'h1;
   localparam logic [3:0] OFF_PINC = 4'h2;
   localparam logic [3:0] OFF_IEN  = 4'h4;
   localparam logic [3:0] OFF_STAT = 4'h5;
   localparam logic [3:0] OFF_CNT  = 4'h6;
   localparam logic [3:0] OFF_CMP  = 4'h8;

   localparam int          CH_SPAN_LG = 4;     // 16 bytes per channel
   localparam int          PSC_W      = 6;     // widest divide is 64
   localparam logic [2:0]  CLR_ON_CMP = 3'd1;

   // terminal value of the prescaler for a rate code
   function automatic logic [PSC_W-1:0] psc_mask(input logic [2:0] sel);
      case (sel)
         3'd1:    return PSC_W'(3);
         3'd2:    return PSC_W'(15);
         3'd3:    return PSC_W'(63);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
   import cmt_pkg::*;
#(
   parameter int PW = PSC_W
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] sel,
   output logic       tick
);

   logic [PW-1:0] div_q;
   logic [PW-1:0] lim;

   assign lim  = PW'(psc_mask(sel));
   assign tick = run && ((div_q & lim) == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (!run)
         div_q <= '0;
      else
         div_q <= (div_q + 1'b1) & lim;
   end

   // R4
   psc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sel inside {3'd1, 3'd2, 3'd3}) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
   import cmt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              wr_ctrl,
   input  logic              wr_mode,
   input  logic              wr_pinc,
   input  logic              wr_ien,
   input  logic              wr_stat,
   input  logic              wr_cnt,
   input  logic              wr_cmp,
   input  logic              rd_stat,
   input  logic [DATA_W-1:0] wdata,
   output logic [7:0]        ctrl_o,
   output logic [7:0]        mode_o,
   output logic [7:0]        pinc_o,
   output logic [7:0]        ien_o,
   output logic              flag_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  cmp_o,
   output logic              irq_o
);

   logic [7:0]       ctrl_q, mode_q, pinc_q, ien_q;
   logic [CNT_W-1:0] cnt_q, cmp_q;
   logic             flag_q, armed_q;
   logic             tick, at_cmp, hit, clr_on;

   cmt_prescaler u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (ctrl_q[2:0]),
      .tick (tick)
   );

   assign at_cmp = (cnt_q == cmp_q);
   assign hit    = tick && at_cmp;
   assign clr_on = (ctrl_q[7:5] == CLR_ON_CMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         pinc_q <= '0;
         ien_q  <= '0;
         cmp_q  <= '1;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[7:0];
         if (wr_mode) mode_q <= wdata[7:0];
         if (wr_pinc) pinc_q <= wdata[7:0];
         if (wr_ien)  ien_q  <= wdata[7:0];
         if (wr_cmp)  cmp_q  <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wr_cnt)
         cnt_q <= wdata[CNT_W-1:0];
      else if (tick)
         cnt_q <= (clr_on && at_cmp) ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         if (hit)
            flag_q <= 1'b1;
         else if (wr_stat && !wdata[0] && armed_q)
            flag_q <= 1'b0;
         if (wr_stat)
            armed_q <= 1'b0;
         else if (rd_stat)
            armed_q <= flag_q;
      end
   end

   assign ctrl_o = ctrl_q;
   assign mode_o = mode_q;
   assign pinc_o = pinc_q;
   assign ien_o  = ien_q;
   assign flag_o = flag_q;
   assign cnt_o  = cnt_q;
   assign cmp_o  = cmp_q;
   assign irq_o  = flag_q && ien_q[0];

   // R3
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt_q));

   // R5
   cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clr_on && at_cmp && !wr_cnt) |=> (cnt_q == '0));

   // R6
   flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick && at_cmp));

   // R7
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !armed_q) |=> flag_q);

   // R9
   cnt_wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt_q == $past(wdata[CNT_W-1:0])));

endmodule

// File: rtl/cmt_group.sv
module cmt_group
   import cmt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);

   localparam int              SEL_W    = ADDR_W - CH_SPAN_LG;
   localparam logic [ADDR_W-1:0] RUN_ADDR = ADDR_W'(NUM_CH << CH_SPAN_LG);

   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("NUM_CH must be 1..8");
      end
      if (CNT_W < 8 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must be 8..DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (NUM_CH >= (1 << SEL_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the channel map");
      end
   endgenerate

   logic [3:0]       off;
   logic [SEL_W-1:0] chsel;
   logic [NUM_CH-1:0] run_q;

   logic [7:0]       ch_ctrl [NUM_CH];
   logic [7:0]       ch_mode [NUM_CH];
   logic [7:0]       ch_pinc [NUM_CH];
   logic [7:0]       ch_ien  [NUM_CH];
   logic             ch_flag [NUM_CH];
   logic [CNT_W-1:0] ch_cnt  [NUM_CH];
   logic [CNT_W-1:0] ch_cmp  [NUM_CH];

   assign off   = bus_addr[3:0];
   assign chsel = bus_addr[ADDR_W-1:CH_SPAN_LG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (bus_wr && bus_addr == RUN_ADDR)
         run_q <= bus_wdata[NUM_CH-1:0];
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic sel;
         assign sel = (chsel == SEL_W'(i));

         cmt_channel #(
            .CNT_W (CNT_W),
            .DATA_W(DATA_W)
         ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q[i]),
            .wr_ctrl(bus_wr && sel && off == OFF_CTRL),
            .wr_mode(bus_wr && sel && off == OFF_MODE),
            .wr_pinc(bus_wr && sel && off == OFF_PINC),
            .wr_ien (bus_wr && sel && off == OFF_IEN),
            .wr_stat(bus_wr && sel && off == OFF_STAT),
            .wr_cnt (bus_wr && sel && off == OFF_CNT),
            .wr_cmp (bus_wr && sel && off == OFF_CMP),
            .rd_stat(bus_rd && sel && off == OFF_STAT),
            .wdata  (bus_wdata),
            .ctrl_o (ch_ctrl[i]),
            .mode_o (ch_mode[i]),
            .pinc_o (ch_pinc[i]),
            .ien_o  (ch_ien[i]),
            .flag_o (ch_flag[i]),
            .cnt_o  (ch_cnt[i]),
            .cmp_o  (ch_cmp[i]),
            .irq_o  (irq[i])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == RUN_ADDR)
         bus_rdata = DATA_W'(run_q);
      for (int i = 0; i < NUM_CH; i++) begin
         if (chsel == SEL_W'(i)) begin
            case (off)
               OFF_CTRL: bus_rdata = DATA_W'(ch_ctrl[i]);
               OFF_MODE: bus_rdata = DATA_W'(ch_mode[i]);
               OFF_PINC: bus_rdata = DATA_W'(ch_pinc[i]);
               OFF_IEN:  bus_rdata = DATA_W'(ch_ien[i]);
               OFF_STAT: bus_rdata = DATA_W'(ch_flag[i]);
               OFF_CNT:  bus_rdata = DATA_W'(ch_cnt[i]);
               OFF_CMP:  bus_rdata = DATA_W'(ch_cmp[i]);
               default:  bus_rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: tb/cmt_group_bench.sv
`timescale 1ns/1ps
module cmt_group_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   localparam logic [7:0] RUN_A = 8'h30;

   always #2 clk = ~clk;

   cmt_group u_cmt_group (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   function automatic logic [7:0] ca(input int ch, input int off);
      return 8'(ch * 16 + off);
   endfunction

   function automatic int divof(input logic [2:0] s);
      case (s)
         3'd1:    return 4;
         3'd2:    return 16;
         3'd3:    return 64;
         default: return 1;
      endcase
   endfunction

   // returns {flag, counter} after a number of ticks
   function automatic logic [16:0] model(input logic [15:0] c0, input logic [15:0] cmpv,
                                         input bit clr, input int ticks);
      logic [15:0] c = c0;
      bit f = 0;
      for (int k = 0; k < ticks; k++) begin
         if (c == cmpv) begin
            f = 1;
            c = clr ? 16'h0 : c + 16'h1;
         end else begin
            c = c + 16'h1;
         end
      end
      return {f, c};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all bus tasks are entered and left at a falling edge
   task automatic bwr(input logic [7:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [15:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic prep(input int ch, input logic [2:0] sel, input bit clr,
                       input logic [15:0] cmpv, input logic [15:0] c0, input bit ien);
      logic [15:0] v;
      bwr(RUN_A, 16'h0);
      bwr(ca(ch, 0), {8'h0, clr ? 3'd1 : 3'd0, 2'b00, sel});
      bwr(ca(ch, 2), 16'h0);
      bwr(ca(ch, 8), cmpv);
      bwr(ca(ch, 6), c0);
      bwr(ca(ch, 1), 16'h0);
      bwr(ca(ch, 4), {15'h0, ien});
      brd(ca(ch, 5), v);
      bwr(ca(ch, 5), 16'h0);
   endtask

   // running window of w+1 clock edges
   task automatic run_for(input logic [7:0] mask, input int w);
      bwr(RUN_A, {8'h0, mask});
      repeat (w) @(negedge clk);
      bwr(RUN_A, 16'h0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      logic [15:0] v;
      logic [16:0] m;
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      brd(ca(0, 0), v); chk("R1 ctrl", v, 0);
      brd(ca(1, 6), v); chk("R1 cnt", v, 0);
      brd(ca(2, 8), v); chk("R1 cmp", v, 16'hFFFF);
      brd(ca(0, 5), v); chk("R1 stat", v, 0);
      brd(RUN_A, v);    chk("R1 run reg", v, 0);
      chk("R1 irq", {29'h0, irq}, 0);

      // R2 map and widths
      bwr(ca(0, 0), 16'hFF23);
      brd(ca(0, 0), v); chk("R2 ctrl width", v, 16'h0023);
      bwr(ca(2, 2), 16'h00A5);
      brd(ca(2, 2), v); chk("R2 pinc readback", v, 16'h00A5);
      bwr(ca(2, 2), 16'h0000);
      brd(ca(0, 3), v); chk("R2 unmapped", v, 0);
      brd(8'h31, v);    chk("R2 unmapped past run", v, 0);

      // R5 free-running wrap through 0xFFFF
      prep(1, 3'd0, 0, 16'h0005, 16'hFFFE, 0);
      run_for(8'h02, 9);
      m = model(16'hFFFE, 16'h0005, 0, 10);
      brd(ca(1, 6), v); chk("R5 wrap count", v, m[15:0]);
      brd(ca(1, 5), v); chk("R6 flag wrap", v, {15'h0, m[16]});

      // R3 shared run bits
      prep(0, 3'd0, 0, 16'hFFFF, 16'h0, 0);
      prep(1, 3'd0, 0, 16'hFFFF, 16'h0, 0);
      bwr(RUN_A, 16'h0003);
      repeat (10) @(negedge clk);
      bwr(RUN_A, 16'h0001);
      repeat (10) @(negedge clk);
      bwr(RUN_A, 16'h0000);
      brd(ca(0, 6), v); chk("R3 ch0 count", v, 22);
      brd(ca(1, 6), v); chk("R3 ch1 count", v, 11);
      repeat (30) @(negedge clk);
      brd(ca(0, 6), v); chk("R3 halted hold", v, 22);

      // R4 prescaler restarts after halt
      prep(2, 3'd3, 0, 16'hFFFF, 16'h0, 0);
      run_for(8'h04, 39);
      run_for(8'h04, 39);
      brd(ca(2, 6), v); chk("R4 restart no tick", v, 0);
      run_for(8'h04, 63);
      brd(ca(2, 6), v); chk("R4 div64 one tick", v, 1);

      // R7 and R10 flag clearing handshake
      prep(0, 3'd0, 1, 16'h0003, 16'h0, 1);
      run_for(8'h01, 5);
      brd(ca(0, 5), v); chk("R6 flag set", v, 1);
      chk("R10 irq high", {31'h0, irq[0]}, 1);
      bwr(ca(0, 5), 16'h0001);
      brd(ca(0, 6), v);
      bwr(ca(0, 5), 16'h0000);
      brd(ca(0, 6), v);
      chk("R7 write one then zero no read", {31'h0, irq[0]}, 1);
      bwr(ca(0, 4), 16'h0000);
      chk("R10 irq masked", {31'h0, irq[0]}, 0);
      bwr(ca(0, 4), 16'h0001);
      brd(ca(0, 5), v); chk("R7 flag still set", v, 1);
      bwr(ca(0, 5), 16'h0000);
      brd(ca(0, 5), v); chk("R7 flag cleared", v, 0);
      chk("R10 irq low", {31'h0, irq[0]}, 0);

      // R9 counter write beats tick
      prep(0, 3'd0, 0, 16'hFFFF, 16'h0, 0);
      bwr(RUN_A, 16'h0001);
      repeat (5) @(negedge clk);
      bwr(ca(0, 6), 16'h1234);
      brd(ca(0, 6), v); chk("R9 write wins", v, 16'h1234);
      brd(ca(0, 6), v); chk("R9 counting resumes", v, 16'h1235);
      bwr(RUN_A, 16'h0000);

      // R8 match on the same edge as an armed clear
      begin : collide
         int guard;
         bit hit;
         prep(0, 3'd0, 1, 16'd20, 16'h0, 0);
         bwr(RUN_A, 16'h0001);
         guard = 0;
         v = 0;
         while (v[0] == 1'b0 && guard < 200) begin
            brd(ca(0, 5), v);
            guard++;
         end
         hit = 0;
         guard = 0;
         while (!hit && guard < 400) begin
            bus_addr = ca(0, 6); bus_rd = 1'b1;
            #1;
            if (bus_rdata == 16'd20) begin
               #0.5;
               bus_rd = 1'b0; bus_addr = ca(0, 5); bus_wdata = 16'h0; bus_wr = 1'b1;
               @(negedge clk);
               bus_wr = 1'b0;
               hit = 1;
            end else begin
               @(negedge clk);
            end
            guard++;
         end
         bus_rd = 1'b0;
         brd(ca(0, 5), v); chk("R8 match beats clear", v, 1);
         bwr(RUN_A, 16'h0000);
      end

      // R4 R5 R6 R10 random mix
      for (int it = 0; it < 12; it++) begin
         int ch, w, ticks;
         logic [2:0] sel;
         bit clr, ien;
         logic [15:0] cmpv, c0;
         ch   = int'($urandom % 3);
         sel  = 3'($urandom % 8);
         clr  = 1'($urandom % 2);
         ien  = 1'($urandom % 2);
         cmpv = 16'($urandom % 12);
         c0   = 16'($urandom % 8);
         w    = int'($urandom % 150);
         prep(ch, sel, clr, cmpv, c0, ien);
         run_for(8'(1 << ch), w);
         ticks = (w + 1) / divof(sel);
         m = model(c0, cmpv, clr, ticks);
         brd(ca(ch, 6), v); chk("R4 R5 random count", v, m[15:0]);
         brd(ca(ch, 5), v); chk("R6 random flag", v, {15'h0, m[16]});
         chk("R10 random irq", {31'h0, irq[ch]}, {31'h0, m[16] & ien});
      end

      done = 1;
      finish_run();
   end

endmodule